// File: doc/BRIEF.md
# Masked Alarm and Interrupt Controller

This block sits beside a calendar clock and turns its time fields and event strobes into one interrupt pin. Four alarm registers hold a BCD target for seconds, minutes, hours and day of month. Each register carries its own ignore bit, so a single set of registers can raise a one-time alarm or a periodic alarm every minute, hour or day. The comparison runs only on the cycle of the one-second update strobe, so each matching second raises the alarm flag once.

Three sticky flags record a watchdog expiry, an alarm match and a power-fail event. Software reads the flags through a small register port, and that read clears them. A per-source enable decides which flags reach the interrupt pin. The pin can hold its active level until the flags are read, or it can give a pulse that is timed on a slow tick. The pin works either as an active-high push-pull driver or as an active-low open-drain driver. For oscillator trimming, a test mode replaces the interrupt with a square wave at half the slow-tick rate.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset every register reads 0x00. A value written to an alarm register (select 0 = seconds, 1 = minutes, 2 = hours, 3 = date) reads back unchanged. The control register (select 4) reads back its implemented bits 7, 6, 5, 2 and 1, and its other bits read 0.
- R2: In an alarm register, bit 7 = 1 removes that field from the comparison. With bit 7 = 0, bits 6:0 must equal the current BCD field. When every field that takes part is equal, flags bit 6 is set.
- R3: The alarm comparison sets flags bit 6 only on a cycle where sec_tick is high. A matching time with no strobe leaves the flag clear.
- R4: The flags register (select 5) shows the watchdog flag in bit 7, the alarm flag in bit 6 and the power-fail flag in bit 5. A read of the flags register returns the current value and clears all three bits. A write to the flags register does not change these bits.
- R5: An event that arrives in the same cycle as a flags read leaves its flag set after the read.
- R6: Control bits 7, 6 and 5 enable the watchdog, alarm and power-fail sources onto the interrupt. A flag whose enable is 0 is still set but does not make the interrupt active.
- R7: With control bit 2 = 1, irq_oe is always 1 and irq_out equals the active state. With control bit 2 = 0, irq_out is 0 and irq_oe is 1 only while the interrupt is active.
- R8: With control bit 1 = 0 (level mode), the interrupt becomes active in the cycle after an enabled event and stays active until the flags register is read.
- R9: With control bit 1 = 1 (pulse mode), an enabled event makes the interrupt active for PULSE_TICKS slow_tick strobes. A flags read ends the pulse early. The flags stay set after the pulse ends.
- R10: Flags bit 4 is a writable and readable calibration bit. While it is 1, irq_oe is 1 and irq_out toggles on every slow_tick strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle strobe, once per second, after the time fields update |
| wdog_expire | input | 1 | One-cycle watchdog timeout event |
| pwr_fail | input | 1 | One-cycle power-fail event |
| slow_tick | input | 1 | Slow timing strobe (nominally 1024 Hz) for the pulse length and the square wave |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; when it selects the flags register, the flags clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_sel |
| irq_out | output | 1 | Interrupt pin output value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The hardest case to reach from the ports is a flags read and a new event in the same clock cycle. If the clear wins, the event is lost without any trace. The bench raises the read strobe and a power-fail strobe on one edge, then checks the next read for the surviving bit. A second hard case is the exact end of a pulse, which is a count of slow strobes and not of clocks. The bench steps the slow strobe one by one and samples the pin one strobe before the end and again at the end.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int N_FIELDS = 4;
  localparam int REG_W    = 8;

  // register selects; alarm fields are indices 0..N_FIELDS-1
  localparam logic [2:0] SEL_ASEC  = 3'd0;
  localparam logic [2:0] SEL_ADATE = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;
  localparam logic [2:0] SEL_FLAGS = 3'd5;

  // bit positions that software decodes
  localparam int B_MASK  = 7;
  localparam int B_WDOG  = 7;
  localparam int B_ALARM = 6;
  localparam int B_PFAIL = 5;
  localparam int B_CAL   = 4;
  localparam int B_POL   = 2;
  localparam int B_PULSE = 1;

  // one alarm field: ignored when its mask bit is set, else equal 7-bit BCD
  function automatic logic field_hit(input logic [REG_W-1:0] alarm,
                                     input logic [REG_W-1:0] now);
    return alarm[B_MASK] || ({1'b0, alarm[6:0]} == now);
  endfunction

  // event wins over clear so that nothing is lost
  function automatic logic [2:0] next_flags(input logic [2:0] cur,
                                            input logic       clr,
                                            input logic [2:0] evt);
    return (clr ? 3'b000 : cur) | evt;
  endfunction
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alm_pkg::*;
(
  input  logic [N_FIELDS-1:0][REG_W-1:0] alarm_regs,
  input  logic [N_FIELDS-1:0][REG_W-1:0] now,
  input  logic                           sec_tick,
  output logic                           hit
);
  logic [N_FIELDS-1:0] field_ok;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    assign field_ok[i] = field_hit(alarm_regs[i], now[i]);
  end

  assign hit = sec_tick && (&field_ok);
endmodule

// File: rtl/flag_bank.sv
module flag_bank (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] evt,
  input  logic       clr,
  output logic [2:0] flags
);
  import alm_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= next_flags(flags, clr, evt);
  end

  // R4: a read with no new event leaves all flags clear
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == 3'b000) |=> (flags == 3'b000));

  // R5: every event that arrives shows up in the next cycle, read or not
  a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 3'b000) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_shaper.sv
module irq_shaper #(
  parameter int PULSE_TICKS = 205
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] flags,
  input  logic [2:0] en,
  input  logic [2:0] evt,
  input  logic       clr,
  input  logic       pulse_mode,
  input  logic       pol_high,
  input  logic       cal_mode,
  input  logic       slow_tick,
  output logic       active,
  output logic       irq_out,
  output logic       irq_oe
);
  localparam int CW = $clog2(PULSE_TICKS + 1);

  logic [CW-1:0] pulse_cnt;
  logic          wave;
  logic          start;
  logic          level_on;

  assign start    = pulse_mode && ((evt & en) != 3'b000);
  assign level_on = (flags & en) != 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pulse_cnt <= '0;
    else if (!pulse_mode)                pulse_cnt <= '0;
    else if (start)                      pulse_cnt <= CW'(PULSE_TICKS);
    else if (clr)                        pulse_cnt <= '0;
    else if (slow_tick && pulse_cnt != 0) pulse_cnt <= pulse_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wave <= 1'b0;
    else if (!cal_mode) wave <= 1'b0;
    else if (slow_tick) wave <= ~wave;
  end

  assign active = pulse_mode ? (pulse_cnt != 0) : level_on;

  always_comb begin
    if (cal_mode) begin
      irq_oe  = 1'b1;
      irq_out = wave;
    end else if (pol_high) begin
      irq_oe  = 1'b1;
      irq_out = active;
    end else begin
      irq_oe  = active;
      irq_out = 1'b0;
    end
  end

  // R9: a flags read with no fresh enabled event ends the pulse
  a_r9_pulse_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && clr && (evt & en) == 3'b000) |=> (pulse_cnt == 0));

  // R7: the open-drain form never drives the pin high
  a_r7_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_mode && !pol_high) |-> !irq_out);

  // R10: the square wave flips on each slow strobe
  a_r10_cal_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode && $past(cal_mode) && $past(slow_tick)) |-> (irq_out != $past(irq_out)));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import alm_pkg::*;
#(
  parameter int PULSE_TICKS = 205
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] cur_sec,
  input  logic [REG_W-1:0] cur_min,
  input  logic [REG_W-1:0] cur_hour,
  input  logic [REG_W-1:0] cur_date,
  input  logic             sec_tick,
  input  logic             wdog_expire,
  input  logic             pwr_fail,
  input  logic             slow_tick,
  input  logic [2:0]       reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_out,
  output logic             irq_oe
);
  logic [N_FIELDS-1:0][REG_W-1:0] alarm_q;
  logic [N_FIELDS-1:0][REG_W-1:0] now;
  logic [2:0] en_q;
  logic       pol_q, pulse_q, cal_q;
  logic [2:0] flags_q;
  logic [2:0] evt;
  logic       alarm_hit;
  logic       flags_clr;
  logic       irq_active;

  assign now       = {cur_date, cur_hour, cur_min, cur_sec};
  assign flags_clr = reg_rd && (reg_sel == SEL_FLAGS);
  assign evt       = {wdog_expire, alarm_hit, pwr_fail};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      en_q    <= '0;
      pol_q   <= 1'b0;
      pulse_q <= 1'b0;
      cal_q   <= 1'b0;
    end else if (reg_wr) begin
      for (int i = 0; i < N_FIELDS; i++)
        if (reg_sel == 3'(i)) alarm_q[i] <= reg_wdata;
      if (reg_sel == SEL_CTRL) begin
        en_q    <= reg_wdata[B_WDOG:B_PFAIL];
        pol_q   <= reg_wdata[B_POL];
        pulse_q <= reg_wdata[B_PULSE];
      end
      if (reg_sel == SEL_FLAGS) cal_q <= reg_wdata[B_CAL];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel <= SEL_ADATE)      reg_rdata = alarm_q[reg_sel[1:0]];
    else if (reg_sel == SEL_CTRL)  reg_rdata = {en_q, 2'b00, pol_q, pulse_q, 1'b0};
    else if (reg_sel == SEL_FLAGS) reg_rdata = {flags_q, cal_q, 4'b0000};
  end

  alarm_match u_match (
    .alarm_regs (alarm_q),
    .now        (now),
    .sec_tick   (sec_tick),
    .hit        (alarm_hit)
  );

  flag_bank u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .clr   (flags_clr),
    .flags (flags_q)
  );

  irq_shaper #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags      (flags_q),
    .en         (en_q),
    .evt        (evt),
    .clr        (flags_clr),
    .pulse_mode (pulse_q),
    .pol_high   (pol_q),
    .cal_mode   (cal_q),
    .slow_tick  (slow_tick),
    .active     (irq_active),
    .irq_out    (irq_out),
    .irq_oe     (irq_oe)
  );

  // R3: the alarm flag cannot rise without the one-second strobe
  a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(flags_q[1]));

  // R6: with every source disabled, level mode never goes active
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 3'b000 && !pulse_q) |-> !irq_active);
endmodule

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;
  localparam int PERIOD = 10;
  localparam int PT     = 205;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = 8'h01;
  logic       sec_tick = 0, wdog_expire = 0, pwr_fail = 0, slow_tick = 0;
  logic [2:0] reg_sel = '0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_out, irq_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rtc_alarm_irq #(.PULSE_TICKS(PT)) u0 (.*);

  // {alarm date,hour,min,sec, time date,hour,min,sec, expected alarm flag}
  localparam logic [64:0] VEC [9] = '{
    {8'h01,8'h12,8'h30,8'h45, 8'h01,8'h12,8'h30,8'h45, 1'b1},
    {8'h01,8'h12,8'h30,8'h45, 8'h01,8'h12,8'h30,8'h46, 1'b0},
    {8'h80,8'h80,8'h80,8'h80, 8'h17,8'h03,8'h22,8'h09, 1'b1},
    {8'h80,8'h80,8'h80,8'h15, 8'h09,8'h07,8'h44,8'h15, 1'b1},
    {8'h80,8'h80,8'h80,8'h15, 8'h09,8'h07,8'h44,8'h16, 1'b0},
    {8'h80,8'h80,8'h30,8'h00, 8'h05,8'h23,8'h30,8'h00, 1'b1},
    {8'h80,8'h06,8'h30,8'h00, 8'h05,8'h07,8'h30,8'h00, 1'b0},
    {8'h25,8'h06,8'h30,8'h00, 8'h25,8'h06,8'h30,8'h00, 1'b1},
    {8'h25,8'h06,8'h30,8'h00, 8'h24,8'h06,8'h30,8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    reg_sel = s; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wd_evt();
    wdog_expire = 1; @(negedge clk); wdog_expire = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1; @(negedge clk); slow_tick = 0; @(negedge clk);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), d); chk("R1 reset value", d, 8'h00);
    end
    chk("R7 idle open-drain oe", {7'b0, irq_oe}, 8'h00);

    // R1 readback
    wr(3'd2, 8'h97); rd(3'd2, d); chk("R1 alarm readback", d, 8'h97);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R1 control readback", d, 8'hE6);
    wr(3'd4, 8'h00);

    // R2 vector table
    for (int v = 0; v < 9; v++) begin
      {cur_date, cur_hour, cur_min, cur_sec} = VEC[v][32:1];
      wr(3'd0, VEC[v][40:33]); wr(3'd1, VEC[v][48:41]);
      wr(3'd2, VEC[v][56:49]); wr(3'd3, VEC[v][64:57]);
      sec_tick = 1; @(negedge clk); sec_tick = 0;
      rd(3'd5, d); chk("R2 alarm match", {7'b0, d[6]}, {7'b0, VEC[v][0]});
    end

    // R3 matching time without strobe
    {cur_date, cur_hour, cur_min, cur_sec} = 32'h25063000;
    repeat (5) @(negedge clk);
    rd(3'd5, d); chk("R3 no strobe no flag", {7'b0, d[6]}, 8'h00);
    sec_tick = 1; @(negedge clk); sec_tick = 0;
    rd(3'd5, d); chk("R3 strobe sets flag", {7'b0, d[6]}, 8'h01);

    // R4 flag positions, read clears, write ignored
    wd_evt(); pwr_fail = 1; @(negedge clk); pwr_fail = 0;
    wr(3'd5, 8'hE0);
    rd(3'd5, d); chk("R4 flag bits", d, 8'hA0);
    rd(3'd5, d); chk("R4 cleared by read", d, 8'h00);
    wr(3'd5, 8'hE0);
    rd(3'd5, d); chk("R4 write ignored", d, 8'h00);

    // R5 read and event in the same cycle
    wd_evt();
    reg_sel = 3'd5; reg_rd = 1; pwr_fail = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; pwr_fail = 0;
    chk("R5 read value", d, 8'h80);
    rd(3'd5, d); chk("R5 event kept", d, 8'h20);

    // R6 disabled source, open-drain level
    wr(3'd4, 8'h80);
    pwr_fail = 1; @(negedge clk); pwr_fail = 0;
    chk("R6 disabled no irq", {6'b0, irq_oe, irq_out}, 8'h00);
    rd(3'd5, d);

    // R8 level mode, R7 open-drain active low
    wd_evt();
    chk("R7 open-drain active", {6'b0, irq_oe, irq_out}, 8'h02);
    ticks(300);
    chk("R8 level holds", {6'b0, irq_oe, irq_out}, 8'h02);
    rd(3'd5, d);
    chk("R8 released by read", {6'b0, irq_oe, irq_out}, 8'h00);

    // R7 push-pull active high
    wr(3'd4, 8'h84);
    chk("R7 push-pull idle", {6'b0, irq_oe, irq_out}, 8'h02);
    wd_evt();
    chk("R7 push-pull active", {6'b0, irq_oe, irq_out}, 8'h03);
    rd(3'd5, d);

    // R9 pulse mode length
    wr(3'd4, 8'hC6);
    wd_evt();
    chk("R9 pulse starts", {7'b0, irq_out}, 8'h01);
    ticks(PT - 1);
    chk("R9 pulse one tick before end", {7'b0, irq_out}, 8'h01);
    ticks(1);
    chk("R9 pulse ended", {7'b0, irq_out}, 8'h00);
    rd(3'd5, d); chk("R9 flag survives pulse", d, 8'h80);

    // R9 early end by read
    wd_evt(); ticks(3);
    rd(3'd5, d);
    chk("R9 read ends pulse", {7'b0, irq_out}, 8'h00);

    // R10 calibration square wave
    wr(3'd5, 8'h10);
    rd(3'd5, d); chk("R10 cal bit reads", d, 8'h10);
    chk("R10 cal oe", {7'b0, irq_oe}, 8'h01);
    d = {7'b0, irq_out};
    ticks(1);
    chk("R10 toggles", {7'b0, irq_out}, {7'b0, ~d[0]});
    ticks(1);
    chk("R10 toggles back", {7'b0, irq_out}, d);
    wr(3'd5, 8'h00);
    chk("R10 cal off", {7'b0, irq_out}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule